// File: doc/BRIEF.md
# Threshold-Triggered Receive Burst FIFO Controller

This block buffers received data between a DMA engine that fills it one dword at a time and a bus master that empties it in bursts. The buffer holds 32 dwords (128 bytes). The block watches its own fill level and decides when to ask for the bus and how long to keep a burst going. A burst ends when the buffer runs dry or when the bus is taken away.

A 2-bit select picks one of four fill thresholds, in steps of a quarter of the capacity. Reaching the threshold raises the bus request. So does the arrival of the final dword of a DMA copy, even when the level is below the threshold. This lets a short copy go out without waiting. The fill side may keep writing while a burst drains the buffer. If the bus is lost while the level is still above the threshold, the request is held high so that a new burst follows at once.

Top module: `rx_burst_fifo`

## Requirements
- R1: After reset, `bus_req` and `rd_valid` are low and `wr_ready` is high.
- R2: The threshold in dwords is set by `thr_sel`: 00 gives 8 dwords (32 bytes), 01 gives 16, 10 gives 24 and 11 gives 32 (full).
- R3: When no end-of-copy dword is pending, `bus_req` stays low while the level is below the threshold. It goes high in the second cycle after the write that brings the level up to the threshold is accepted.
- R4: Data leaves in the order it was written. `rd_valid` is high only while `bus_req` and `bus_gnt` are high, `bus_lost` is low and the buffer is not empty. Each cycle with `rd_valid` high removes one dword.
- R5: A write accepted with `wr_last` high raises `bus_req` in the second cycle after that write, even when the level is below the threshold.
- R6: The end-of-copy condition clears when the dword that was written with `wr_last` is read out. After that, a level below the threshold raises no request.
- R7: Writes are accepted while a burst is running. A write and a read in the same cycle leave the level unchanged. The burst continues until every dword, including those written during it, has been read.
- R8: During a burst, a cycle with `bus_lost` high (or `bus_gnt` low) transfers no data. If the level is then above the threshold, `bus_req` stays high with no low cycle.
- R9: A burst that ends by emptying the buffer, or by losing the bus while the level is at or below the threshold, drops `bus_req` in the following cycle.
- R10: The buffer holds 32 dwords. `wr_ready` is low while it is full, and a write offered while it is full is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_sel | input | 2 | Burst threshold select |
| wr_valid | input | 1 | Fill side offers a dword |
| wr_data | input | 32 | Dword from the fill side |
| wr_last | input | 1 | Offered dword is the last of the current copy |
| wr_ready | output | 1 | Buffer can accept a dword (not full) |
| bus_gnt | input | 1 | Bus master owns the bus for this block |
| bus_lost | input | 1 | Ownership taken by another master this cycle |
| bus_req | output | 1 | Bus request |
| rd_valid | output | 1 | `rd_data` is transferred this cycle |
| rd_data | output | 32 | Dword driven toward the bus |

## Verification
The assertions assume that `bus_gnt` is raised only in answer to `bus_req`. They also assume that `thr_sel` does not change while data is buffered, because a change would move the threshold under a burst that has already started. The bench grants the bus only after it has seen the request and changes `thr_sel` only when the buffer is empty and idle. It signals a bus loss by dropping the grant and pulsing `bus_lost` for one cycle, which keeps the preemption checks within the behaviour the properties describe.

// File: rtl/rbf_pkg.sv
// Package: shared types and sizing helpers for the receive burst FIFO.
// Assumes: four threshold steps, one quarter of the depth each.
package rbf_pkg;

    // Number of selectable threshold steps (2-bit select).
    localparam int NUM_LVL = 4;

    // Burst request state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2
    } burst_st_e;

endpackage

// File: rtl/rbf_store.sv
// Module: rbf_store
// Dword storage with read and write pointers, a fill count and a count of
// end-of-copy marks still inside the buffer.
// Assumes: DEPTH is a power of two of at least 4; the caller reads only
// when the count is non-zero.
module rbf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         wr_last,
    input  logic                         pop,
    output logic                         push,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         eoc_pend,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W:0]  mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [CNT_W-1:0] last_cnt;
    logic             head_last;

    // Accept a write only when there is room.
    assign full = (count == CNT_W'(DEPTH));
    assign push = wr_valid && !full;

    // Present the head entry and its end-of-copy tag.
    assign rd_data   = mem[rptr][DATA_W-1:0];
    assign head_last = mem[rptr][DATA_W];
    assign eoc_pend  = (last_cnt != '0);

    // Store the tagged dword (storage needs no reset).
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= {wr_last, wr_data};
        end
    end

    // Advance the pointers with wrap at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) begin
                wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
            end
        end
    end

    // Track the fill level; a write and a read together cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Count end-of-copy marks that have entered and not yet left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cnt <= '0;
        end else begin
            case ({push && wr_last, pop && head_last})
                2'b10:   last_cnt <= last_cnt + 1'b1;
                2'b01:   last_cnt <= last_cnt - 1'b1;
                default: last_cnt <= last_cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);                                   // R10
    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));                                     // R4
    AST_MARKS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        last_cnt <= count);                                         // R6

endmodule

// File: rtl/rbf_level_cmp.sv
// Module: rbf_level_cmp
// Compares the fill count with the selected quarter-step threshold.
// Assumes: thr_sel is stable while a burst is pending or running.
module rbf_level_cmp
    import rbf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic [1:0]                 thr_sel,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       at_thr,
    output logic                       above_thr
);
    localparam int CNT_W   = $clog2(DEPTH+1);
    localparam int QUARTER = DEPTH / NUM_LVL;

    logic [CNT_W-1:0] thr_tab [NUM_LVL];
    logic [CNT_W-1:0] thr_dw;

    // Build one threshold per select code, a quarter of the depth apart.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_thr
        assign thr_tab[g] = CNT_W'((g + 1) * QUARTER);
    end

    // Pick the threshold and compare it with the level.
    always_comb begin
        thr_dw    = thr_tab[thr_sel];
        at_thr    = (count >= thr_dw);
        above_thr = (count >  thr_dw);
    end

endmodule

// File: rtl/rbf_burst_fsm.sv
// Module: rbf_burst_fsm
// Decides when to request the bus, when to read, and when a burst ends.
// Assumes: bus_gnt is only given while bus_req is high; bus_lost pulses
// when another master takes the bus.
module rbf_burst_fsm
    import rbf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_gnt,
    input  logic                       bus_lost,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       push,
    input  logic                       at_thr,
    input  logic                       above_thr,
    input  logic                       eoc_pend,
    output logic                       pop,
    output logic                       bus_req
);
    localparam int CNT_W = $clog2(DEPTH+1);

    burst_st_e state;
    burst_st_e state_nx;
    logic      empty;
    logic      start;
    logic      owned;
    logic      drains;

    // Derive the start and ownership conditions.
    always_comb begin
        empty  = (count == '0);
        start  = at_thr || (eoc_pend && !empty);
        owned  = bus_gnt && !bus_lost;
        pop    = (state == ST_BURST) && owned && !empty;
        drains = pop && !push && (count == CNT_W'(1));
    end

    // Choose the next state of the request machine.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (owned) state_nx = ST_BURST;
            end
            ST_BURST: begin
                if (!owned) begin
                    state_nx = above_thr ? ST_REQ : ST_IDLE;
                end else if (drains || empty) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Register the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Request the bus in every state except idle.
    assign bus_req = (state != ST_IDLE);

    AST_THR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && at_thr) |=> bus_req);                  // R3
    AST_EOC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && eoc_pend && !empty) |=> bus_req);      // R5
    AST_QUIET_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !at_thr && !eoc_pend) |=> !bus_req);   // R6
    AST_LOST_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !owned && above_thr) |=> bus_req);    // R8
    AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && drains) |=> !bus_req);                // R9
    AST_NO_READ_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lost |-> !pop);                                         // R8

endmodule

// File: rtl/rx_burst_fifo.sv
// Module: rx_burst_fifo (top)
// Receive burst FIFO: buffers DMA dwords and requests bus bursts on a
// programmable threshold or at the end of a copy.
// Assumes: the bus side takes rd_data in every cycle rd_valid is high.
module rx_burst_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_ready,
    input  logic              bus_gnt,
    input  logic              bus_lost,
    output logic              bus_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [CNT_W-1:0] count;
    logic             push;
    logic             pop;
    logic             full;
    logic             eoc_pend;
    logic             at_thr;
    logic             above_thr;

    rbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_last  (wr_last),
        .pop      (pop),
        .push     (push),
        .full     (full),
        .count    (count),
        .eoc_pend (eoc_pend),
        .rd_data  (rd_data)
    );

    rbf_level_cmp #(.DEPTH(DEPTH)) u_cmp (
        .thr_sel   (thr_sel),
        .count     (count),
        .at_thr    (at_thr),
        .above_thr (above_thr)
    );

    rbf_burst_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_gnt   (bus_gnt),
        .bus_lost  (bus_lost),
        .count     (count),
        .push      (push),
        .at_thr    (at_thr),
        .above_thr (above_thr),
        .eoc_pend  (eoc_pend),
        .pop       (pop),
        .bus_req   (bus_req)
    );

    assign wr_ready = !full;
    assign rd_valid = pop;

    AST_READ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bus_req && bus_gnt));                         // R4
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && !rd_valid) |=> !wr_ready);                    // R10

endmodule

// File: tb/sim_rx_burst_fifo.sv
`timescale 1ns/1ps
module sim_rx_burst_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  thr_sel = 2'b00;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_last = 1'b0;
    logic        wr_ready;
    logic        bus_gnt = 1'b0;
    logic        bus_lost = 1'b0;
    logic        bus_req;
    logic        rd_valid;
    logic [31:0] rd_data;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] model [$];
    logic [31:0] seed = 32'h1000_0000;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    rx_burst_fifo u0 (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .wr_ready(wr_ready), .bus_gnt(bus_gnt), .bus_lost(bus_lost),
        .bus_req(bus_req), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One dword write; the model keeps it only if it was accepted.
    task automatic wr(input bit last);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = seed;
        wr_last  = last;
        #1;
        if (wr_ready) model.push_back(seed);
        seed = seed + 32'h11;
        @(posedge clk);
        #0.5;
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) wr(1'b0);
    endtask

    // Grant and collect n dwords (plus nfill writes during the burst).
    task automatic pop_n(input int n, input int nfill, input string req);
        int got = 0;
        int cyc = 0;
        while (got < n && cyc < 400) begin
            @(negedge clk);
            bus_gnt = 1'b1;
            if (cyc < nfill) begin
                wr_valid = 1'b1;
                wr_data  = seed;
            end else begin
                wr_valid = 1'b0;
            end
            #1;
            if (rd_valid) begin
                chk(model.size() > 0 && rd_data == model[0], req, rd_data,
                    model.size() > 0 ? model[0] : 32'hx);
                if (model.size() > 0) void'(model.pop_front());
                got++;
            end
            if (wr_valid && wr_ready) begin
                model.push_back(seed);
                seed = seed + 32'h11;
            end
            cyc++;
            @(posedge clk);
        end
        chk(got == n, req, got, n);
        #0.5;
        wr_valid = 1'b0;
    endtask

    // Pop n, then release the bus and check the request has gone.
    task automatic drain(input int n, input int nfill, input string req);
        pop_n(n, nfill, req);
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
        chk(!bus_req && !rd_valid, {req, " R9 end"}, bus_req, 0);
    endtask

    task automatic wait_req();
        int k = 0;
        while (!bus_req && k < 50) begin
            @(negedge clk);
            #1;
            k++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(!bus_req, "R1 bus_req", bus_req, 0);
        chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
        chk(wr_ready, "R1 wr_ready", wr_ready, 1);
    endtask

    // R2 and R3: each threshold code, tested one dword short and then at it.
    task automatic t_threshold(input logic [1:0] sel);
        int thr = (int'(sel) + 1) * 8;
        thr_sel = sel;
        wr_n(thr - 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(!bus_req, "R3 below threshold", bus_req, 0);
        end
        wr(1'b0);
        @(negedge clk);
        #1;
        chk(!bus_req, "R2 not yet", bus_req, 0);
        @(negedge clk);
        #1;
        chk(bus_req, "R2 request at threshold", bus_req, 1);
        drain(thr, 0, "R4 order");
    endtask

    task automatic t_end_of_copy();
        thr_sel = 2'b00;
        wr_n(2);
        wr(1'b1);
        @(negedge clk);
        #1;
        chk(!bus_req, "R5 not yet", bus_req, 0);
        @(negedge clk);
        #1;
        chk(bus_req, "R5 end-of-copy request", bus_req, 1);
        drain(3, 0, "R5 drain");
        wr_n(2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            chk(!bus_req, "R6 cleared", bus_req, 0);
        end
        wr_n(6);
        wait_req();
        drain(8, 0, "R6 drain");
    endtask

    task automatic t_fill_during();
        thr_sel = 2'b00;
        wr_n(8);
        wait_req();
        drain(13, 5, "R7 fill during burst");
        chk(model.size() == 0, "R7 model empty", model.size(), 0);
    endtask

    task automatic t_preempt();
        thr_sel = 2'b00;
        wr_n(20);
        wait_req();
        pop_n(3, 0, "R8 first part");
        @(negedge clk);
        bus_gnt  = 1'b0;
        bus_lost = 1'b1;
        #1;
        chk(!rd_valid, "R8 no data when lost", rd_valid, 0);
        @(negedge clk);
        bus_lost = 1'b0;
        #1;
        chk(bus_req, "R8 request held", bus_req, 1);
        pop_n(9, 0, "R8 second part");
        @(negedge clk);
        bus_gnt  = 1'b0;
        bus_lost = 1'b1;
        #1;
        chk(!rd_valid, "R8 no data when lost", rd_valid, 0);
        @(negedge clk);
        bus_lost = 1'b0;
        #1;
        chk(!bus_req, "R9 drop at threshold", bus_req, 0);
        @(negedge clk);
        #1;
        chk(bus_req, "R3 request again", bus_req, 1);
        drain(8, 0, "R8 rest");
    endtask

    task automatic t_full();
        int acc = 0;
        thr_sel = 2'b11;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            #1;
            if (wr_ready) acc++;
            wr(1'b0);
        end
        chk(acc == 32, "R10 accepts 32", acc, 32);
        @(negedge clk);
        #1;
        chk(!wr_ready, "R10 full", wr_ready, 0);
        wr(1'b0);
        chk(model.size() == 32, "R10 model", model.size(), 32);
        wait_req();
        drain(32, 0, "R10 drain");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        t_reset();
        for (int s = 0; s < 4; s++) t_threshold(2'(s));
        t_end_of_copy();
        t_fill_during();
        t_preempt();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule